// File: doc/BRIEF.md
# SMBus Host Controller for Memory-Module Devices

This block is a single-target SMBus/I2C master that carries out one byte or word read or write per command. Typical targets are the serial configuration EEPROM and the temperature sensor on a memory module. Software configures a control register, starts a transfer by writing a command word with its start bit set, and then polls a status word. The status word reports busy, the completion flags, a bus-error flag and the returned data. The 7-bit target address is assembled from two places: its upper four bits come from the control register and its lower three bits come from the command word.

Reads are sent as a combined transfer: start, address with write, command byte, repeated start, address with read, then one or two data bytes. The master acknowledges every data byte except the last, which it NACKs, and then sends stop. While no command is running and the poll enable is set, the block reads a fixed register of a fixed sensor address as a word on a fixed period. It keeps the latest result in a separate register. SCL and SDA are open-drain, each brought out as a pull-low enable and a line input. Every bit lasts four quarter periods of `QCYC` clocks. A target that holds SCL low stretches the current quarter.

Top module: `smb_host_ctl`

## Requirements
- R1: After reset both pull-low enables are 0, and the control word (address 0), the status word (address 2) and the poll result (address 3) all read 0. While the block is not busy, neither line is pulled low.
- R2: A write to address 1 with bit 31 set starts a transaction when the block is idle and control bit 27 is 1. Status bit 28 (busy) reads 1 from the next cycle until the transaction ends. The target address is {control[31:28], command[26:24]}.
- R3: Command bit 27 selects a write and bit 29 selects word size. A byte write puts command bits 7:0 on the wire after the command byte (bits 23:16) and ignores bits 15:8. A word write sends two data bytes to consecutive target offsets.
- R4: Control bit 8 selects the word byte order for both reads and writes. When it is 0, bits 15:8 carry the first byte on the wire. When it is 1, bits 7:0 carry the first byte on the wire.
- R5: A finished word read returns its data in status bits 15:0. A byte read returns its byte in bits 7:0 with bits 15:8 zero. A write leaves status bits 15:0 unchanged.
- R6: Status bit 31 (read valid) is cleared only when a read starts and is set when it finishes. Status bit 30 (write done) is cleared only when a write starts and is set when it finishes. A write never changes bit 31 and a read never changes bit 30.
- R7: Status bit 29 (bus error) is set when the target does not acknowledge a byte the master sends. The transaction still ends with stop and the completion flag. The bit is cleared when the next command starts.
- R8: A transaction not finished within `TO_CYC` cycles is abandoned. Both lines are released, busy drops, bit 29 is set and the completion flag stays clear.
- R9: When control bit 26 is 1, a write command is dropped: busy stays 0 and nothing appears on the bus.
- R10: When control bit 27 is 0, every command is dropped.
- R11: When control bit 9 is 1 and the block is idle, a word read of register `POLL_REG` at address `POLL_ADDR` starts every `POLL_GAP` idle cycles, with busy set while it runs. Its result, in the byte order of R4, is stored in the word at address 3. Status bits 31:29 and 15:0 are not changed by it.
- R12: A command written while the block is busy is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 command, 2 status, 3 poll result |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA line level |

## Verification
Busy is due on the first cycle after the clock edge that takes the command write. The bench reads the status word at the next falling edge to confirm it. Completion flags, read data, bus error and the poll result are all settled in the cycle busy drops. So the bench polls status once per cycle and judges them only after it sees busy low. A dropped command must show busy low one cycle after the write, and the bench checks the target memory after enough cycles for any bus activity to have landed. The abandon path is timed by counting status reads from the trigger until busy falls, which must lie within a few cycles of `TO_CYC`.

// File: rtl/smb_host_ctl.sv
module smb_host_ctl #(
  parameter int          QCYC      = 250,
  parameter int          TO_CYC    = 3500000,
  parameter int          POLL_GAP  = 1000000,
  parameter logic [6:0]  POLL_ADDR = 7'h18,
  parameter logic [7:0]  POLL_REG  = 8'h05
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        scl_oe,
  input  logic        scl_in,
  output logic        sda_oe,
  input  logic        sda_in
);
  localparam int DW = $clog2(QCYC + 1);
  localparam int TW = $clog2(TO_CYC + 1);
  localparam int PW = $clog2(POLL_GAP + 1);

  typedef enum logic [1:0] {S_IDLE, S_STA, S_BIT, S_STO} st_t;

  st_t         st;
  logic [1:0]  q;
  logic [DW-1:0] div;
  logic [3:0]  bitn;
  logic [2:0]  stp;
  logic [7:0]  sh, rx0;
  logic [15:0] wdat, rdat, pdat;
  logic [6:0]  taddr;
  logic [7:0]  tcmd;
  logic        t_word, t_wr, t_poll, t_smb, t_bad;
  logic [3:0]  c_hi;
  logic        c_ckok, c_wrdis, c_poll, c_smb;
  logic        f_rdv, f_wrd, f_err;
  logic        sda_r;
  logic [TW-1:0] tocnt;
  logic [PW-1:0] pcnt;

  logic busy, cmd_wr, trig, poll_go, hold, tick, rx_step, sda_want;
  logic [2:0] last_stp;
  logic [7:0] wb_first, wb_second;
  logic [15:0] result;
  logic unused_ok;

  assign unused_ok = reg_wdata[30];
  assign busy     = (st != S_IDLE);
  assign cmd_wr   = reg_we && (reg_addr == 2'd1);
  assign trig     = cmd_wr && reg_wdata[31] && !busy && c_ckok && !(reg_wdata[27] && c_wrdis);
  assign poll_go  = !busy && !cmd_wr && c_poll && c_ckok && (pcnt == PW'(POLL_GAP - 1));
  assign scl_oe   = busy && !q[1];
  assign sda_oe   = sda_r;
  assign hold     = busy && q[1] && !scl_in;
  assign tick     = busy && (div == DW'(QCYC - 1)) && !hold;
  assign last_stp = t_wr ? (3'd2 + {2'b0, t_word}) : (3'd3 + {2'b0, t_word});
  assign rx_step  = !t_wr && (stp >= 3'd3);
  assign wb_first  = (!t_word || t_smb) ? wdat[7:0] : wdat[15:8];
  assign wb_second = t_smb ? wdat[15:8] : wdat[7:0];
  assign result   = !t_word ? {8'h00, rx0} : (t_smb ? {sh, rx0} : {rx0, sh});

  function automatic logic [7:0] tx_byte(input logic [2:0] s);
    case (s)
      3'd0:    return {taddr, 1'b0};
      3'd1:    return tcmd;
      3'd2:    return t_wr ? wb_first : {taddr, 1'b1};
      default: return wb_second;
    endcase
  endfunction

  always_comb begin
    case (st)
      S_STA:   sda_want = (q == 2'd2);
      S_STO:   sda_want = (q != 2'd2);
      S_BIT:   sda_want = (bitn != 4'd8) ? (!rx_step && !sh[7])
                                         : (rx_step && (stp != last_stp));
      default: sda_want = 1'b0;
    endcase
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {c_hi, c_ckok, c_wrdis, 16'h0, c_poll, c_smb, 8'h0};
      2'd2:    reg_rdata = {f_rdv, f_wrd, f_err, busy, 12'h0, rdat};
      2'd3:    reg_rdata = {16'h0, pdat};
      default: reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; q <= '0; div <= '0; bitn <= '0; stp <= '0;
      sh <= '0; rx0 <= '0; wdat <= '0; rdat <= '0; pdat <= '0;
      taddr <= '0; tcmd <= '0; t_word <= 1'b0; t_wr <= 1'b0;
      t_poll <= 1'b0; t_smb <= 1'b0; t_bad <= 1'b0;
      c_hi <= '0; c_ckok <= 1'b0; c_wrdis <= 1'b0; c_poll <= 1'b0; c_smb <= 1'b0;
      f_rdv <= 1'b0; f_wrd <= 1'b0; f_err <= 1'b0; sda_r <= 1'b0;
      tocnt <= '0; pcnt <= '0;
    end else begin
      if (reg_we && reg_addr == 2'd0) begin
        c_hi    <= reg_wdata[31:28];
        c_ckok  <= reg_wdata[27];
        c_wrdis <= reg_wdata[26];
        c_poll  <= reg_wdata[9];
        c_smb   <= reg_wdata[8];
      end

      tocnt <= busy ? tocnt + 1'b1 : '0;
      if (busy || !c_poll || !c_ckok || poll_go) pcnt <= '0;
      else pcnt <= pcnt + 1'b1;

      if (!busy || tick) div <= '0;
      else if (!hold) div <= div + 1'b1;

      if (trig || poll_go) begin
        st     <= S_STA;
        q      <= 2'd0;
        stp    <= 3'd0;
        t_bad  <= 1'b0;
        t_smb  <= c_smb;
        t_poll <= !trig;
        taddr  <= trig ? {c_hi, reg_wdata[26:24]} : POLL_ADDR;
        tcmd   <= trig ? reg_wdata[23:16] : POLL_REG;
        wdat   <= reg_wdata[15:0];
        t_word <= trig ? reg_wdata[29] : 1'b1;
        t_wr   <= trig && reg_wdata[27];
        if (trig) begin
          f_err <= 1'b0;
          if (reg_wdata[27]) f_wrd <= 1'b0;
          else f_rdv <= 1'b0;
        end
      end else if (busy && tocnt == TW'(TO_CYC - 1)) begin
        st    <= S_IDLE;
        sda_r <= 1'b0;
        if (!t_poll) f_err <= 1'b1;
      end else if (tick) begin
        if (q != 2'd3) begin
          q     <= q + 1'b1;
          sda_r <= sda_want;
        end else begin
          q <= 2'd0;
          case (st)
            S_STA: begin
              st   <= S_BIT;
              bitn <= 4'd0;
              sh   <= tx_byte(stp);
            end
            S_BIT: begin
              if (bitn != 4'd8) begin
                sh   <= {sh[6:0], sda_in};
                bitn <= bitn + 1'b1;
              end else begin
                if (rx_step && stp == 3'd3) rx0 <= sh;
                if (!rx_step && sda_in) begin
                  t_bad <= 1'b1;
                  st    <= S_STO;
                end else if (stp == last_stp) begin
                  st <= S_STO;
                end else begin
                  stp <= stp + 1'b1;
                  if (!t_wr && stp == 3'd1) st <= S_STA;
                  else begin
                    bitn <= 4'd0;
                    sh   <= tx_byte(3'(stp + 1'b1));
                  end
                end
              end
            end
            S_STO: begin
              st <= S_IDLE;
              if (t_poll) begin
                if (!t_bad) pdat <= result;
              end else begin
                f_err <= t_bad;
                if (t_wr) f_wrd <= 1'b1;
                else begin
                  f_rdv <= 1'b1;
                  if (!t_bad) rdat <= result;
                end
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd1 && reg_wdata[31] && !busy && c_ckok && !reg_wdata[27]) |=> busy);

  // R6
  rdv_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && t_wr) |-> $stable(f_rdv));

  // R5
  byte_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(f_rdv) && !$past(t_word) && !$past(t_bad)) |-> (rdat[15:8] == 8'h00));

  // R7
  err_from_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_err) |-> $past(busy));

  // R8
  abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !t_poll && tocnt == TW'(TO_CYC - 1) && !cmd_wr) |=> (f_err && !busy));

  // R9
  wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd1 && reg_wdata[31] && reg_wdata[27] && c_wrdis && !busy) |=> !busy);
endmodule

// File: tb/smb_host_ctl_test.sv
`timescale 1ns/1ps
module smb_host_ctl_test;
  localparam int TO = 3000;
  localparam int GAP = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic scl_oe, sda_oe;
  logic s_drv = 1'b0;
  logic s_stretch = 1'b0;
  wire scl = !(scl_oe || s_stretch);
  wire sda = !(sda_oe || s_drv);

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  smb_host_ctl #(.QCYC(2), .TO_CYC(TO), .POLL_GAP(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_oe(scl_oe), .scl_in(scl), .sda_oe(sda_oe), .sda_in(sda));

  // target model: devices 0x50 (index 0) and 0x18 (index 1)
  logic [7:0] mem [0:511];
  logic [7:0] mdl [0:511];
  localparam int M_IDLE = 0, M_RX = 1, M_RXA = 2, M_TX = 3, M_TXA = 4;
  int md = M_IDLE;
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic [7:0] s_sh, s_tb, s_ptr;
  logic [3:0] s_cnt;
  logic s_aph, s_first, s_rd, s_dev, s_nk;

  always @(negedge clk) begin
    if (!rst_n) begin
      md <= M_IDLE; s_drv <= 1'b0;
    end else begin
      if (scl && p_scl && p_sda && !sda) begin
        md <= M_RX; s_cnt <= 0; s_aph <= 1'b1; s_drv <= 1'b0;
      end else if (scl && p_scl && !p_sda && sda) begin
        md <= M_IDLE; s_drv <= 1'b0;
      end else if (scl && !p_scl) begin
        if (md == M_RX) begin s_sh <= {s_sh[6:0], sda}; s_cnt <= s_cnt + 1; end
        if (md == M_TXA) s_nk <= sda;
      end else if (!scl && p_scl) begin
        case (md)
          M_RX: if (s_cnt == 8) begin
            if (s_aph) begin
              if (s_sh[7:1] == 7'h50 || s_sh[7:1] == 7'h18) begin
                s_dev <= (s_sh[7:1] == 7'h18); s_rd <= s_sh[0];
                s_drv <= 1'b1; md <= M_RXA; s_aph <= 1'b0; s_first <= 1'b1;
              end else md <= M_IDLE;
            end else begin
              if (s_first) s_ptr <= s_sh;
              else begin mem[{s_dev, s_ptr}] <= s_sh; s_ptr <= s_ptr + 1; end
              s_first <= 1'b0; s_drv <= 1'b1; md <= M_RXA;
            end
          end
          M_RXA, M_TXA: begin
            if (md == M_TXA && s_nk) begin md <= M_IDLE; s_drv <= 1'b0; end
            else if (s_rd) begin
              s_tb <= mem[{s_dev, s_ptr}]; s_drv <= !mem[{s_dev, s_ptr}][7];
              s_ptr <= s_ptr + 1; s_cnt <= 1; md <= M_TX;
            end else begin s_drv <= 1'b0; md <= M_RX; s_cnt <= 0; end
          end
          M_TX: if (s_cnt == 8) begin s_drv <= 1'b0; md <= M_TXA; end
                else begin s_drv <= !s_tb[3'(7 - s_cnt)]; s_cnt <= s_cnt + 1; end
          default: ;
        endcase
      end
      p_scl <= scl; p_sda <= sda;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_wdata = 32'h0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] s;
    cyc = 0;
    do begin rd_reg(2'd2, s); cyc++; end while (s[28] && cyc < 20000);
  endtask

  function automatic logic [31:0] mk_ctrl(input logic [3:0] hi, input logic ck,
      input logic wd, input logic pe, input logic smb);
    return {hi, ck, wd, 16'h0, pe, smb, 8'h0};
  endfunction

  function automatic logic [31:0] mk_cmd(input logic word, input logic wr,
      input logic [2:0] lo, input logic [7:0] off, input logic [15:0] d);
    return {1'b1, 1'b0, word, 1'b0, wr, lo, off, d};
  endfunction

  task automatic do_op(input logic dev, input logic word, input logic wr,
      input logic smb, input logic [7:0] off, input logic [15:0] d);
    logic [31:0] s0, s1;
    logic [8:0] i0, i1;
    logic [15:0] exp;
    int cyc;
    i0 = {dev, off};
    i1 = {dev, 8'(off + 8'd1)};
    wr_reg(2'd0, mk_ctrl(dev ? 4'h3 : 4'hA, 1'b1, 1'b0, 1'b0, smb));
    rd_reg(2'd2, s0);
    wr_reg(2'd1, mk_cmd(word, wr, 3'b000, off, d));
    rd_reg(2'd2, s1);
    chk("R2 busy after trigger", {31'h0, s1[28]}, 32'h1);
    wait_idle(cyc);
    rd_reg(2'd2, s1);
    chk("R7 no error on acked transfer", {31'h0, s1[29]}, 32'h0);
    if (wr) begin
      if (!word) mdl[i0] = d[7:0];
      else begin
        mdl[i0] = smb ? d[7:0] : d[15:8];
        mdl[i1] = smb ? d[15:8] : d[7:0];
      end
      chk("R6 write done set", {31'h0, s1[30]}, 32'h1);
      chk("R6 read valid untouched by write", {31'h0, s1[31]}, {31'h0, s0[31]});
      chk("R5 write keeps data field", {16'h0, s1[15:0]}, {16'h0, s0[15:0]});
      chk("R3 R4 first target byte", {24'h0, mem[i0]}, {24'h0, mdl[i0]});
      chk("R3 R4 next target byte", {24'h0, mem[i1]}, {24'h0, mdl[i1]});
    end else begin
      if (!word) exp = {8'h00, mdl[i0]};
      else exp = smb ? {mdl[i1], mdl[i0]} : {mdl[i0], mdl[i1]};
      chk("R6 read valid set", {31'h0, s1[31]}, 32'h1);
      chk("R6 write done untouched by read", {31'h0, s1[30]}, {31'h0, s0[30]});
      chk("R4 R5 read data", {16'h0, s1[15:0]}, {16'h0, exp});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] s, s0;
    int cyc;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 512; i++) begin mem[i] = 8'($urandom); mdl[i] = mem[i]; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 scl released", {31'h0, scl_oe}, 32'h0);
    chk("R1 sda released", {31'h0, sda_oe}, 32'h0);
    rd_reg(2'd0, s); chk("R1 control zero", s, 32'h0);
    rd_reg(2'd2, s); chk("R1 status zero", s, 32'h0);
    rd_reg(2'd3, s); chk("R1 poll word zero", s, 32'h0);

    // directed word order cases
    do_op(1'b0, 1'b1, 1'b1, 1'b0, 8'h10, 16'hA1B2);
    do_op(1'b0, 1'b1, 1'b0, 1'b1, 8'h10, 16'h0);
    do_op(1'b0, 1'b0, 1'b1, 1'b0, 8'h20, 16'hEE3C); // R3 high byte ignored
    do_op(1'b0, 1'b0, 1'b0, 1'b0, 8'h20, 16'h0);
    do_op(1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 16'h1234); // offset wrap

    // random mix
    for (int k = 0; k < 24; k++)
      do_op(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            8'($urandom), 16'($urandom));

    // R12 command during busy
    wr_reg(2'd0, mk_ctrl(4'hA, 1'b1, 1'b0, 1'b0, 1'b0));
    wr_reg(2'd1, mk_cmd(1'b1, 1'b0, 3'b000, 8'h40, 16'h0));
    repeat (5) @(negedge clk);
    wr_reg(2'd1, mk_cmd(1'b0, 1'b1, 3'b000, 8'h44, {8'h0, ~mdl[9'h044]}));
    wait_idle(cyc);
    repeat (20) @(negedge clk);
    chk("R12 command while busy dropped", {24'h0, mem[9'h044]}, {24'h0, mdl[9'h044]});

    // R9 write blocked
    wr_reg(2'd0, mk_ctrl(4'hA, 1'b1, 1'b1, 1'b0, 1'b0));
    rd_reg(2'd2, s0);
    wr_reg(2'd1, mk_cmd(1'b0, 1'b1, 3'b000, 8'h50, {8'h0, ~mdl[9'h050]}));
    rd_reg(2'd2, s);
    chk("R9 blocked write not busy", {31'h0, s[28]}, 32'h0);
    repeat (200) @(negedge clk);
    rd_reg(2'd2, s);
    chk("R9 blocked write keeps done flag", {31'h0, s[30]}, {31'h0, s0[30]});
    chk("R9 blocked write no bus effect", {24'h0, mem[9'h050]}, {24'h0, mdl[9'h050]});

    // R10 clock enable off
    wr_reg(2'd0, mk_ctrl(4'hA, 1'b0, 1'b0, 1'b0, 1'b0));
    wr_reg(2'd1, mk_cmd(1'b0, 1'b1, 3'b000, 8'h51, {8'h0, ~mdl[9'h051]}));
    rd_reg(2'd2, s);
    chk("R10 command dropped when clock disabled", {31'h0, s[28]}, 32'h0);
    repeat (200) @(negedge clk);
    chk("R10 no bus effect", {24'h0, mem[9'h051]}, {24'h0, mdl[9'h051]});

    // R7 no acknowledge (address 0x51)
    wr_reg(2'd0, mk_ctrl(4'hA, 1'b1, 1'b0, 1'b0, 1'b0));
    wr_reg(2'd1, mk_cmd(1'b0, 1'b0, 3'b001, 8'h00, 16'h0));
    wait_idle(cyc);
    rd_reg(2'd2, s);
    chk("R7 error on no acknowledge", {31'h0, s[29]}, 32'h1);
    chk("R7 read still completes", {31'h0, s[31]}, 32'h1);
    do_op(1'b0, 1'b0, 1'b0, 1'b0, 8'h33, 16'h0); // R7 error cleared, checked inside

    // R8 abandon on held clock
    s_stretch = 1'b1;
    wr_reg(2'd1, mk_cmd(1'b0, 1'b0, 3'b000, 8'h00, 16'h0));
    wait_idle(cyc);
    s_stretch = 1'b0;
    rd_reg(2'd2, s);
    chk("R8 error after abandon", {31'h0, s[29]}, 32'h1);
    chk("R8 read valid stays clear", {31'h0, s[31]}, 32'h0);
    chk("R8 abandon time", {31'h0, (cyc >= TO - 6 && cyc <= TO + 6)}, 32'h1);
    repeat (20) @(negedge clk);

    // R11 automatic poll, both byte orders
    mem[9'h105] = 8'h1C; mdl[9'h105] = 8'h1C;
    mem[9'h106] = 8'h7E; mdl[9'h106] = 8'h7E;
    rd_reg(2'd2, s0);
    for (int m = 0; m < 2; m++) begin
      wr_reg(2'd0, mk_ctrl(4'hA, 1'b1, 1'b0, 1'b1, 1'(m)));
      cyc = 0;
      do begin rd_reg(2'd2, s); cyc++; end while (!s[28] && cyc < 5000);
      chk("R11 poll raises busy", {31'h0, s[28]}, 32'h1);
      wait_idle(cyc);
      wr_reg(2'd0, mk_ctrl(4'hA, 1'b1, 1'b0, 1'b0, 1'(m)));
      wait_idle(cyc);
      rd_reg(2'd3, s);
      chk("R11 R4 poll result", s, (m == 0) ? 32'h1C7E : 32'h7E1C);
      rd_reg(2'd2, s);
      chk("R11 poll leaves status flags", {29'h0, s[31:29]}, {29'h0, s0[31:29]});
      chk("R11 poll leaves status data", {16'h0, s[15:0]}, {16'h0, s0[15:0]});
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule